// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block is the controller end of the two-wire management bus that Ethernet PHYs expose. It generates the management clock and shifts out complete frames on the data line. On reads it turns the line around and shifts in 16 bits of register data. A host asks for one access at a time with a single-cycle `start`. The request gives the direction, the addressing style, a 5-bit PHY address, a 5-bit register or device field, a 16-bit extended register address and the write data. The block raises `done` for one cycle when the access is over.

There are two addressing styles. The short style carries the register number directly in the frame. The extended style takes two frames back to back to the same PHY and device. The first frame loads the 16-bit register address. The second frame does the read or the write. The data line is exposed as separate output, output-enable and input pins so that the pad lives outside the block. A read whose turnaround bit is not driven low is treated as having no responder, unless a per-PHY mask says that PHY's turnaround is not to be trusted. The clock half-period, in system clocks, comes from an input that is latched when a request is accepted.

Top module: `mdio_master`

## Requirements
- R1: `mdc` is low whenever the block is idle. During an access, every low phase and every high phase of `mdc` lasts exactly H system clocks. H is `half_period` as sampled on the accepting edge, and a value of 0 counts as 1.
- R2: Each frame opens with 32 bit-clocks in which the master drives 1.
- R3: A short-style frame continues with start bits 0,1 and opcode 1,0 for a read or 0,1 for a write. The 5-bit PHY address follows, then the 5-bit register field, each sent MSB first.
- R4: In a write frame and in an extended address frame, the master drives 1 then 0 after the register field, then 16 data bits MSB first. It then releases the line (`mdio_oe`=0) for one more bit-clock.
- R5: An extended access first sends an address frame: start 0,0, opcode 0,0, the PHY address, the device field and `req_addr` as the 16 data bits. A second frame follows at once, with start 0,0, opcode 1,1 for a read or 0,1 for a write, and the same PHY and device fields.
- R6: In a read frame, the master releases the line right after the register field and samples one turnaround bit. If that bit is 0, it samples 16 data bits MSB first and then clocks one more released bit. Each bit is sampled at the end of the `mdc` high phase. It then returns the data on `rdata` with `ta_err`=0.
- R7: If the sampled turnaround bit is 1 and bit `req_phy` of `ta_ignore_mask` is 0, the master clocks 32 more released bit-clocks and then completes with `rdata`=16'hFFFF and `ta_err`=1.
- R8: If bit `req_phy` of `ta_ignore_mask` is 1, the turnaround value is ignored and the read proceeds as in R6.
- R9: While an access is running, `mdio_out` and `mdio_oe` change only on the edge where `mdc` falls.
- R10: `done` is a one-cycle pulse exactly 2·H·N clocks after the accepting edge. N is the total number of bit-clocks: 65 for a write frame, 64 for a good read, 79 for a failed read, plus 65 for an extended address frame. `rdata` and `ta_err` are valid with `done` and hold until the next completion. A write leaves `rdata` unchanged and clears `ta_err`.
- R11: `busy` rises on the accepting edge and falls with `done`. A `start` while busy is ignored and does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_c45 | input | 1 | 1 = extended two-frame access |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number (short) or device number (extended) |
| req_addr | input | 16 | Extended register address |
| req_wdata | input | 16 | Write data |
| half_period | input | 8 | Management clock half-period in system clocks |
| ta_ignore_mask | input | 32 | Per-PHY turnaround-check disable |
| mdio_in | input | 1 | Data line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value to drive |
| mdio_oe | output | 1 | Pad drive enable |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Read result |
| ta_err | output | 1 | Turnaround failure flag |

## Verification
Each bit is due H clocks after the previous `mdc` fall, when `mdc` rises. The bench samples at the falling clock edge just after each rise. It takes the next entry from a queue of expected bits built from the requirements and answers released slots from a PHY response queue. The `done` pulse is due exactly 2·H·N clocks after the accepting edge. The bench counts clocks from that edge and checks the count, `rdata` and `ta_err` at the first sample where `done` is seen. It checks that `done` is low one clock later. Every sample also measures the length of each `mdc` phase and flags any data change that does not coincide with an `mdc` fall.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_TURN,
    S_RDATA,
    S_FLUSH,
    S_TAIL
  } mdio_state_t;

  localparam logic [1:0] START_SHORT = 2'b01;
  localparam logic [1:0] START_EXT   = 2'b00;
  localparam logic [1:0] OPC_ADDR    = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_RD_SH   = 2'b10;
  localparam logic [1:0] OPC_RD_EXT  = 2'b11;
  localparam logic [1:0] TA_DRIVE    = 2'b10;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HP_W-1:0] half,
  output logic            mdc,
  output logic            bit_end
);

  logic [HP_W-1:0] cnt;
  logic            last;

  assign last    = (cnt == half - 1'b1);
  assign bit_end = run && mdc && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half));

endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
  import mdio_pkg::*;
#(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int CNT_W   = 7
) (
  input  logic              c45,
  input  logic              rd,
  input  logic              aph,
  input  logic [PHY_AW-1:0] phy,
  input  logic [REG_AW-1:0] rg,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRE_LEN+4+PHY_AW+REG_AW+2+DATA_W-1:0] frame,
  output logic [CNT_W-1:0]  nbits,
  output logic              wtype
);

  localparam int HDR_END = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int FR_W    = HDR_END + 2 + DATA_W;

  logic [1:0] st2;
  logic [1:0] op2;

  always_comb begin
    st2 = c45 ? START_EXT : START_SHORT;
    if (aph)      op2 = OPC_ADDR;
    else if (c45) op2 = rd ? OPC_RD_EXT : OPC_WRITE;
    else          op2 = rd ? OPC_RD_SH : OPC_WRITE;
    wtype = aph || !rd;
    frame = {{PRE_LEN{1'b1}}, st2, op2, phy, rg, TA_DRIVE, (aph ? addr : wdata)};
    nbits = wtype ? CNT_W'(FR_W) : CNT_W'(HDR_END);
  end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int FLUSH_LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     req_read,
  input  logic                     req_c45,
  input  logic [PHY_AW-1:0]        req_phy,
  input  logic [REG_AW-1:0]        req_reg,
  input  logic [DATA_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [(1<<PHY_AW)-1:0]   ta_ignore_mask,
  input  logic                     bit_end,
  input  logic                     mdio_in,
  output logic                     mdio_out,
  output logic                     mdio_oe,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ta_err
);

  localparam int FR_W  = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int CNT_W = $clog2(FR_W + FLUSH_LEN + 1);

  mdio_state_t       st;
  logic              rd_q, c45_q, aph_q, wtype_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] addr_q, wd_q, shin;
  logic [FR_W-1:0]   shreg;
  logic [CNT_W-1:0]  cnt;

  logic              idle;
  logic [FR_W-1:0]   fr;
  logic [CNT_W-1:0]  fr_nbits;
  logic              fr_wtype;

  assign idle = (st == S_IDLE);
  assign busy = !idle;

  mdio_frame_fmt #(
    .PHY_AW (PHY_AW),
    .REG_AW (REG_AW),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN),
    .CNT_W  (CNT_W)
  ) u_fmt (
    .c45  (idle ? req_c45   : c45_q),
    .rd   (idle ? req_read  : rd_q),
    .aph  (idle ? req_c45   : 1'b0),
    .phy  (idle ? req_phy   : phy_q),
    .rg   (idle ? req_reg   : reg_q),
    .addr (idle ? req_addr  : addr_q),
    .wdata(idle ? req_wdata : wd_q),
    .frame(fr),
    .nbits(fr_nbits),
    .wtype(fr_wtype)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      rd_q     <= 1'b0;
      c45_q    <= 1'b0;
      aph_q    <= 1'b0;
      wtype_q  <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      shin     <= '0;
      shreg    <= '0;
      cnt      <= '0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      ta_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            rd_q     <= req_read;
            c45_q    <= req_c45;
            aph_q    <= req_c45;
            phy_q    <= req_phy;
            reg_q    <= req_reg;
            addr_q   <= req_addr;
            wd_q     <= req_wdata;
            wtype_q  <= fr_wtype;
            shreg    <= fr;
            mdio_out <= fr[FR_W-1];
            mdio_oe  <= 1'b1;
            cnt      <= fr_nbits - 1'b1;
            st       <= S_SEND;
          end
        end
        S_SEND: begin
          if (bit_end) begin
            if (cnt == '0) begin
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b1;
              st       <= wtype_q ? S_TAIL : S_TURN;
            end else begin
              shreg    <= shreg << 1;
              mdio_out <= shreg[FR_W-2];
              cnt      <= cnt - 1'b1;
            end
          end
        end
        S_TURN: begin
          if (bit_end) begin
            if (mdio_in && !ta_ignore_mask[phy_q]) begin
              cnt <= CNT_W'(FLUSH_LEN - 1);
              st  <= S_FLUSH;
            end else begin
              cnt <= CNT_W'(DATA_W - 1);
              st  <= S_RDATA;
            end
          end
        end
        S_RDATA: begin
          if (bit_end) begin
            shin <= {shin[DATA_W-2:0], mdio_in};
            if (cnt == '0) st <= S_TAIL;
            else           cnt <= cnt - 1'b1;
          end
        end
        S_FLUSH: begin
          if (bit_end) begin
            if (cnt == '0) begin
              st     <= S_IDLE;
              done   <= 1'b1;
              rdata  <= '1;
              ta_err <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_TAIL: begin
          if (bit_end) begin
            if (aph_q) begin
              aph_q    <= 1'b0;
              wtype_q  <= fr_wtype;
              shreg    <= fr;
              mdio_out <= fr[FR_W-1];
              mdio_oe  <= 1'b1;
              cnt      <= fr_nbits - 1'b1;
              st       <= S_SEND;
            end else begin
              st     <= S_IDLE;
              done   <= 1'b1;
              ta_err <= 1'b0;
              if (rd_q) rdata <= shin;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  flush_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ta_err) |-> (rdata == '1));

  // R8
  ta_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_end && st == S_TURN && ta_ignore_mask[phy_q]) |=> (st == S_RDATA));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(phy_q) && $stable(rd_q) && $stable(c45_q) && $stable(reg_q)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int FLUSH_LEN = 32,
  parameter int HP_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   req_read,
  input  logic                   req_c45,
  input  logic [PHY_AW-1:0]      req_phy,
  input  logic [REG_AW-1:0]      req_reg,
  input  logic [DATA_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [HP_W-1:0]        half_period,
  input  logic [(1<<PHY_AW)-1:0] ta_ignore_mask,
  input  logic                   mdio_in,
  output logic                   mdc,
  output logic                   mdio_out,
  output logic                   mdio_oe,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      rdata,
  output logic                   ta_err
);

  logic [HP_W-1:0] hp_q;
  logic            bit_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_q <= HP_W'(1);
    end else if (start && !busy) begin
      hp_q <= (half_period == '0) ? HP_W'(1) : half_period;
    end
  end

  mdio_clkgen #(.HP_W(HP_W)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .half   (hp_q),
    .mdc    (mdc),
    .bit_end(bit_end)
  );

  mdio_seq #(
    .PHY_AW   (PHY_AW),
    .REG_AW   (REG_AW),
    .DATA_W   (DATA_W),
    .PRE_LEN  (PRE_LEN),
    .FLUSH_LEN(FLUSH_LEN)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .req_read      (req_read),
    .req_c45       (req_c45),
    .req_phy       (req_phy),
    .req_reg       (req_reg),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .ta_ignore_mask(ta_ignore_mask),
    .bit_end       (bit_end),
    .mdio_in       (mdio_in),
    .mdio_out      (mdio_out),
    .mdio_oe       (mdio_oe),
    .busy          (busy),
    .done          (done),
    .rdata         (rdata),
    .ta_err        (ta_err)
  );

  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R9
  data_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !($stable(mdio_out) && $stable(mdio_oe))) |-> $fell(mdc));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_read = 1'b0;
  logic        req_c45 = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  half_period = 8'd2;
  logic [31:0] ta_ignore_mask = 32'h0000_0200;
  logic        mdio_in = 1'b1;
  logic        mdc, mdio_out, mdio_oe, busy, done, ta_err;
  logic [15:0] rdata;

  always #5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst(rst), .start(start), .req_read(req_read), .req_c45(req_c45),
    .req_phy(req_phy), .req_reg(req_reg), .req_addr(req_addr), .req_wdata(req_wdata),
    .half_period(half_period), .ta_ignore_mask(ta_ignore_mask), .mdio_in(mdio_in),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .rdata(rdata), .ta_err(ta_err)
  );

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int resp_q[$];
  int cur_h = 2;
  int stream_err = 0;
  int mdc_err = 0;
  int edge_err = 0;
  int run_len = 0;
  int e_bit;
  int r_bit;
  logic prev_mdc = 1'b0;
  logic prev_out = 1'b1;
  logic prev_oe = 1'b0;
  logic prev_busy = 1'b0;
  bit   lo_valid = 1'b0;
  logic [15:0] last_rdata = 16'h0000;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural PHY and bus observer, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst) begin
      prev_mdc = 1'b0; run_len = 0; lo_valid = 1'b0;
      prev_busy = 1'b0; prev_out = mdio_out; prev_oe = mdio_oe;
    end else begin
      if (busy && prev_busy && (mdio_out !== prev_out || mdio_oe !== prev_oe)
          && !(prev_mdc === 1'b1 && mdc === 1'b0))
        edge_err++;
      if (mdc !== prev_mdc) begin
        if (prev_mdc === 1'b1 && run_len != cur_h) mdc_err++;
        if (prev_mdc === 1'b0 && lo_valid && run_len != cur_h) mdc_err++;
        if (mdc === 1'b1) begin
          if (exp_q.size() == 0) stream_err++;
          else begin
            e_bit = exp_q.pop_front();
            if (e_bit == 2) begin
              if (mdio_oe !== 1'b0) stream_err++;
              r_bit = (resp_q.size() != 0) ? resp_q.pop_front() : 1;
              mdio_in = r_bit[0];
            end else if (mdio_oe !== 1'b1 || mdio_out !== e_bit[0]) begin
              stream_err++;
            end
          end
        end
        lo_valid = (mdc === 1'b0) && (busy === 1'b1);
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_mdc = mdc; prev_out = mdio_out; prev_oe = mdio_oe; prev_busy = busy;
    end
  end

  task automatic push_n(input int v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic push_vec(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(int'(v[i]));
  endtask

  task automatic run_txn(input string tag, input bit c45, input bit rd, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] ad, input logic [15:0] wd,
                         input logic [15:0] pd, input bit ta_bad, input int h, input bit intrude);
    int nbits;
    int t;
    logic [15:0] exp_rd;
    bit exp_err;
    exp_q.delete(); resp_q.delete();
    stream_err = 0; mdc_err = 0; edge_err = 0; cur_h = h; nbits = 0;
    if (c45) begin
      push_n(1, 32); push_n(0, 4); push_vec({11'd0, phy}, 5); push_vec({11'd0, rg}, 5);
      push_n(1, 1); push_n(0, 1); push_vec(ad, 16); push_n(2, 1);
      resp_q.push_back(1); nbits += 65;
    end
    push_n(1, 32);
    if (c45) begin push_n(0, 2); push_n(rd ? 1 : 0, 1); push_n(1, 1); end
    else begin push_n(0, 1); push_n(1, 1); push_n(rd ? 1 : 0, 1); push_n(rd ? 0 : 1, 1); end
    push_vec({11'd0, phy}, 5); push_vec({11'd0, rg}, 5);
    if (!rd) begin
      push_n(1, 1); push_n(0, 1); push_vec(wd, 16); push_n(2, 1);
      resp_q.push_back(1); nbits += 65;
      exp_rd = last_rdata; exp_err = 1'b0;
    end else begin
      push_n(2, 1); resp_q.push_back(ta_bad ? 1 : 0);
      if (ta_bad && !ta_ignore_mask[phy]) begin
        push_n(2, 32);
        for (int i = 0; i < 32; i++) resp_q.push_back(1);
        nbits += 79; exp_rd = 16'hFFFF; exp_err = 1'b1;
      end else begin
        push_n(2, 17);
        for (int i = 15; i >= 0; i--) resp_q.push_back(int'(pd[i]));
        resp_q.push_back(1);
        nbits += 64; exp_rd = pd; exp_err = 1'b0;
      end
    end
    @(negedge clk);
    req_c45 = c45; req_read = rd; req_phy = phy; req_reg = rg;
    req_addr = ad; req_wdata = wd; half_period = 8'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    chk("R11", {tag, " busy after accept"}, busy, 1);
    while (done !== 1'b1 && t < 2 * h * nbits + 50) begin
      if (intrude && t == 20) begin
        start = 1'b1; req_read = ~rd; req_c45 = ~c45; req_phy = ~phy; half_period = 8'(h + 3);
      end
      if (intrude && t == 21) start = 1'b0;
      @(negedge clk);
      t++;
    end
    chk("R10", {tag, " completion latency"}, t, 2 * h * nbits);
    chk(tag, {tag, " bit stream mismatches"}, stream_err + exp_q.size(), 0);
    chk("R1", {tag, " mdc phase length errors"}, mdc_err, 0);
    chk("R1", {tag, " mdc low at completion"}, mdc, 0);
    chk("R9", {tag, " data changes off mdc fall"}, edge_err, 0);
    chk(tag, {tag, " rdata"}, rdata, exp_rd);
    chk(tag, {tag, " ta_err"}, ta_err, exp_err);
    @(negedge clk);
    chk("R10", {tag, " done single cycle"}, done, 0);
    chk("R11", {tag, " idle after done"}, busy, 0);
    chk("R10", {tag, " rdata held"}, rdata, exp_rd);
    last_rdata = exp_rd;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset mdc", mdc, 0);
    chk("R4", "reset mdio_oe", mdio_oe, 0);
    chk("R11", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset rdata", rdata, 0);
    // short write, with an ignored start mid-frame
    run_txn("R2/R3/R4/R11", 1'b0, 1'b0, 5'd5, 5'h1A, 16'h0000, 16'hA5C3, 16'h0000, 1'b0, 2, 1'b1);
    // short good read
    run_txn("R3/R6", 1'b0, 1'b1, 5'd3, 5'd2, 16'h0000, 16'h0000, 16'h1234, 1'b0, 3, 1'b0);
    // short read, turnaround high, unmasked PHY
    run_txn("R7", 1'b0, 1'b1, 5'd4, 5'd1, 16'h0000, 16'h0000, 16'h5555, 1'b1, 2, 1'b0);
    // short read, turnaround high, masked PHY 9
    run_txn("R8", 1'b0, 1'b1, 5'd9, 5'd7, 16'h0000, 16'h0000, 16'h0F0F, 1'b1, 2, 1'b0);
    // extended write
    run_txn("R5/R4", 1'b1, 1'b0, 5'd1, 5'd7, 16'hBEEF, 16'h55AA, 16'h0000, 1'b0, 2, 1'b0);
    // extended read, wider clock, ignored start
    run_txn("R5/R6/R11", 1'b1, 1'b1, 5'd31, 5'd3, 16'h0001, 16'h0000, 16'h8001, 1'b0, 5, 1'b1);
    // extended read, failing turnaround, fastest clock
    run_txn("R5/R7", 1'b1, 1'b1, 5'd0, 5'd30, 16'h7E81, 16'h0000, 16'h1111, 1'b1, 1, 1'b0);
    // short write at a 400 ns management clock period
    run_txn("R1/R4", 1'b0, 1'b0, 5'd17, 5'd0, 16'h0000, 16'h0001, 16'h0000, 1'b0, 20, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule